// File: doc/BRIEF.md
# I2C SCL Period Generator

This block shapes the serial clock of an I2C master. While the byte controller holds its run request, the block repeats SCL periods. Each period has a low phase, during which the block drives its pull-low enable, and a high phase, during which SCL is released. The low phase is timed from the cycle the pull-low starts. The high phase is timed only from the clock edge at which the SCL input is first seen high. The rise time of the line, and any slave holding SCL low (clock stretching), therefore lengthen the period rather than eat into the programmed high time.

Both phase lengths come from 9-bit count inputs. One count unit lasts one or two input clocks, selected by a prescale input. A second configuration input states whether the ninth count bit exists. Without it, counts reach at most 255.

For the data shifter, the block emits two one-cycle strobes:
- a fall strobe in the first cycle of each low phase, where the next data bit may change;
- a rise strobe in the first counted cycle of each high phase, where the bit is sampled.

When the run request drops, SCL is released on the next cycle and all timing state is cleared.

Top module: `scl_period_gen`

## Requirements
- R1: After reset, scl_pull, fall_stb and rise_stb are all 0, and they stay 0 while run is 0.
- R2: The low phase holds scl_pull at 1 for exactly Leff*U consecutive cycles, counted from the first cycle scl_pull is 1. Leff is the effective low count and U is the count unit in clocks.
- R3: After the low phase, scl_pull is 0 and the high count does not start until a clock edge samples scl_in at 1. From that edge the high phase lasts Heff*U cycles. With no stretching, scl_pull is therefore 0 for 1+Heff*U cycles per period.
- R4: If scl_in stays 0 after scl_pull is released (a slave stretching), the block waits as long as needed, with no timeout, and then still counts the full Heff*U cycles.
- R5: U is 1 when count_div2 is 0 and 2 when count_div2 is 1.
- R6: When ext_bit_en is 1, bit 8 of low_count and high_count is part of the count (maximum 511). When ext_bit_en is 0, bit 8 is ignored (maximum 255).
- R7: A count value of zero (after any bit-8 masking) is treated as one unit.
- R8: fall_stb is 1 for exactly one cycle per period, in the first cycle scl_pull is 1, and never otherwise.
- R9: rise_stb is 1 for exactly one cycle per period, in the cycle after the edge at which scl_in was sampled high to start the high count. scl_pull is 0 in that cycle.
- R10: When run is 0 at a clock edge, scl_pull is 0 in the following cycle. A later run restarts with a full low phase.
- R11: While run stays 1, periods follow back to back: the end of a high phase is immediately followed by the next low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Request to generate SCL periods |
| low_count | input | 9 | Low phase length in count units |
| high_count | input | 9 | High phase length in count units |
| count_div2 | input | 1 | 1: one unit is two clocks; 0: one clock |
| ext_bit_en | input | 1 | 1: bit 8 of the counts is used |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_pull | output | 1 | 1 drives SCL low |
| fall_stb | output | 1 | One-cycle strobe at the start of each low phase |
| rise_stb | output | 1 | One-cycle strobe at the start of the high count |

## Verification
The bench holds SCL low after release to imitate a stretching slave. A design that started the high count on release would then show a high phase shorter by the stretch, and its rise strobe would come too early.

Zero counts and bit 8 under both settings of ext_bit_en are tested. An off-by-one in the effective-count logic would give a zero-length or 256-unit phase, or would count a bit that should be ignored. The two-clock unit exposes a prescaler that is not cleared at phase entry, because the first phase would then come out one clock short.

Dropping run in mid-period, then restarting, catches a counter that is not cleared: the restarted low phase would be short.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_LOW     = 2'd1,
    PH_RELEASE = 2'd2,
    PH_HIGH    = 2'd3
  } scl_phase_e;
endpackage

// File: rtl/sclgen_count_fix.sv
module sclgen_count_fix #(
  parameter int CNT_W = 9
) (
  input  logic [CNT_W-1:0] raw,
  input  logic             ext_en,
  output logic [CNT_W-1:0] eff
);
  localparam int MSB = CNT_W - 1;
  logic [CNT_W-1:0] masked;

  always_comb begin
    masked = raw;
    if (!ext_en) masked[MSB] = 1'b0;
    eff = (masked == '0) ? CNT_W'(1) : masked;
  end
endmodule

// File: rtl/sclgen_prescale.sv
module sclgen_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic div2,
  output logic tick
);
  logic ph_q, ph_d, ph_en;

  always_comb begin
    ph_en = clr | div2;
    ph_d  = clr ? 1'b0 : ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= 1'b0;
    else if (ph_en) ph_q <= ph_d;
  end

  assign tick = ~div2 | ph_q;
endmodule

// File: rtl/sclgen_span_cnt.sv
module sclgen_span_cnt #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | step;
    cnt_d  = clr ? '0 : cnt_q + CNT_W'(1);
    last   = step && (cnt_q == limit - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] low_count,
  input  logic [CNT_W-1:0] high_count,
  input  logic             count_div2,
  input  logic             ext_bit_en,
  input  logic             scl_in,
  output logic             scl_pull,
  output logic             fall_stb,
  output logic             rise_stb
);
  import sclgen_pkg::*;

  scl_phase_e       st_q, st_d;
  logic             clr, tick, step, last;
  logic             fall_d, rise_d;
  logic [CNT_W-1:0] lo_eff, hi_eff, limit;

  sclgen_count_fix #(.CNT_W(CNT_W)) u_lo_fix (
    .raw(low_count), .ext_en(ext_bit_en), .eff(lo_eff)
  );
  sclgen_count_fix #(.CNT_W(CNT_W)) u_hi_fix (
    .raw(high_count), .ext_en(ext_bit_en), .eff(hi_eff)
  );

  sclgen_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr), .div2(count_div2), .tick(tick)
  );

  assign step  = tick && (st_q == PH_LOW || st_q == PH_HIGH);
  assign limit = (st_q == PH_HIGH) ? hi_eff : lo_eff;

  sclgen_span_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .limit(limit), .last(last)
  );

  always_comb begin
    st_d   = st_q;
    clr    = 1'b0;
    fall_d = 1'b0;
    rise_d = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        clr = 1'b1;
        if (run) begin
          st_d   = PH_LOW;
          fall_d = 1'b1;
        end
      end
      PH_LOW: begin
        if (!run) begin
          st_d = PH_IDLE;
          clr  = 1'b1;
        end else if (last) begin
          st_d = PH_RELEASE;
          clr  = 1'b1;
        end
      end
      PH_RELEASE: begin
        if (!run) begin
          st_d = PH_IDLE;
          clr  = 1'b1;
        end else if (scl_in) begin
          st_d   = PH_HIGH;
          clr    = 1'b1;
          rise_d = 1'b1;
        end
      end
      PH_HIGH: begin
        if (!run) begin
          st_d = PH_IDLE;
          clr  = 1'b1;
        end else if (last) begin
          st_d   = PH_LOW;
          clr    = 1'b1;
          fall_d = 1'b1;
        end
      end
      default: begin
        st_d = PH_IDLE;
        clr  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PH_IDLE;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
    end else begin
      st_q     <= st_d;
      fall_stb <= fall_d;
      rise_stb <= rise_d;
    end
  end

  assign scl_pull = (st_q == PH_LOW);
endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic scl_in,
  input logic scl_pull,
  input logic fall_stb,
  input logic rise_stb
);
  // R8
  fall_at_pull_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> fall_stb);

  // R8
  fall_only_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> scl_pull);

  // R9
  rise_while_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> !scl_pull);

  // R3
  rise_after_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> $past(scl_in));

  // R10
  release_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !scl_pull);

  // R8
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_stb && rise_stb));
endmodule

bind scl_period_gen scl_period_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .scl_in(scl_in),
  .scl_pull(scl_pull), .fall_stb(fall_stb), .rise_stb(rise_stb)
);

// File: tb/scl_period_gen_bench.sv
module scl_period_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       run;
  logic [8:0] low_count, high_count;
  logic       count_div2, ext_bit_en;
  logic       stretch;
  logic       scl_in;
  logic       scl_pull, fall_stb, rise_stb;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_in = ~(scl_pull | stretch);

  scl_period_gen u_scl_period_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .low_count(low_count),
    .high_count(high_count), .count_div2(count_div2), .ext_bit_en(ext_bit_en),
    .scl_in(scl_in), .scl_pull(scl_pull), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(input int lo, input int hi, input bit d2, input bit ext);
    @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    low_count = 9'(lo); high_count = 9'(hi); count_div2 = d2; ext_bit_en = ext;
  endtask

  // Measures one period starting at a sample where scl_pull is (or becomes) 1.
  task automatic measure(input int exp_lo, input int exp_hi, input int k, input string req);
    int lo = 0, hi = 0, fcnt = 0, rcnt = 0, rpos = 0;
    bit fall_first = 1'b0;
    while (!scl_pull) @(negedge clk);
    stretch = (k > 1);
    while (scl_pull) begin
      lo++;
      if (fall_stb) begin
        fcnt++;
        if (lo == 1) fall_first = 1'b1;
      end
      if (rise_stb) rcnt = rcnt + 100;
      @(negedge clk);
    end
    while (!scl_pull) begin
      hi++;
      if (hi == k) stretch = 1'b0;
      if (rise_stb) begin
        rcnt++;
        rpos = hi;
      end
      if (fall_stb) fcnt = fcnt + 100;
      @(negedge clk);
    end
    check(lo == exp_lo, {req, " R2 low length"}, lo, exp_lo);
    check(hi == exp_hi, {req, " R3 released length"}, hi, exp_hi);
    check(fcnt == 1 && fall_first, {req, " R8 fall strobe"}, fcnt, 1);
    check(rcnt == 1 && rpos == k + 1, {req, " R9 rise strobe position"}, rpos, k + 1);
  endtask

  task automatic t_reset;
    run = 1'b0; stretch = 1'b0;
    low_count = 9'd4; high_count = 9'd3; count_div2 = 1'b0; ext_bit_en = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!scl_pull && !fall_stb && !rise_stb, "R1 outputs in reset", scl_pull, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(!scl_pull && !fall_stb && !rise_stb, "R1 idle with run low",
            {scl_pull, fall_stb, rise_stb}, 0);
    end
  endtask

  task automatic t_basic;
    configure(4, 3, 1'b0, 1'b1);
    run = 1'b1;
    @(negedge clk);
    measure(4, 4, 1, "basic p1");
    measure(4, 4, 1, "R11 basic p2");
    measure(4, 4, 1, "R11 basic p3");
  endtask

  task automatic t_prescale;
    configure(3, 2, 1'b1, 1'b1);
    run = 1'b1;
    @(negedge clk);
    measure(6, 5, 1, "R5 div2 p1");
    measure(6, 5, 1, "R5 div2 p2");
  endtask

  task automatic t_stretch;
    configure(2, 2, 1'b0, 1'b1);
    run = 1'b1;
    @(negedge clk);
    measure(2, 8, 6, "R4 stretch 6");
    measure(2, 3, 1, "R4 after stretch");
    measure(2, 42, 40, "R4 stretch 40");
  endtask

  task automatic t_wide;
    configure(9'h101, 9'h100, 1'b0, 1'b1);
    run = 1'b1;
    @(negedge clk);
    measure(257, 257, 1, "R6 ninth bit used");
    configure(9'h105, 9'h102, 1'b0, 1'b0);
    run = 1'b1;
    @(negedge clk);
    measure(5, 3, 1, "R6 ninth bit ignored");
    configure(9'hFF, 9'h1FF, 1'b0, 1'b0);
    run = 1'b1;
    @(negedge clk);
    measure(255, 256, 1, "R6 narrow maximum");
  endtask

  task automatic t_zero;
    configure(0, 0, 1'b0, 1'b1);
    run = 1'b1;
    @(negedge clk);
    measure(1, 2, 1, "R7 zero counts");
    measure(1, 2, 1, "R7 zero counts p2");
    configure(9'h100, 0, 1'b1, 1'b0);
    run = 1'b1;
    @(negedge clk);
    measure(2, 3, 1, "R7 masked to zero div2");
  endtask

  task automatic t_stop;
    configure(5, 4, 1'b0, 1'b1);
    run = 1'b1;
    @(negedge clk);
    check(scl_pull == 1'b1, "R10 low started", scl_pull, 1);
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(scl_pull == 1'b0, "R10 released after stop", scl_pull, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(!scl_pull && !fall_stb && !rise_stb, "R10 stays released",
            {scl_pull, fall_stb, rise_stb}, 0);
    end
    run = 1'b1;
    @(negedge clk);
    measure(5, 5, 1, "R10 restart full low");
    @(negedge clk);
    run = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset;
    t_basic;
    t_prescale;
    t_stretch;
    t_wide;
    t_zero;
    t_stop;
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule